// File: doc/BRIEF.md
# Port-Write Capture Unit

This block receives RapidIO port-write packets from the transport side on a simple valid/ready word stream and keeps one of them in a single 64-byte slot. The slot holds sixteen 32-bit words. Software reads the captured words through a small 32-bit register port, clears the interrupt flag and then releases the slot with a clear-queue command. Only after that release can another packet be stored.

While the slot is occupied, any packet that arrives is dropped and a discard flag is raised. A packet that is not exactly sixteen words long is a transaction error and is not kept. The error flag can only be cleared while the unit is disabled. When the unit is disabled, arriving packets are accepted and discarded without any trace. A single level interrupt combines the flags with their enables.

Register map:
- Word address 0 is the mode register.
- Word address 1 is the status register.
- Word addresses 16 to 31 return the captured words, word 0 first.
- Every other address reads as zero.

Top module: `pwr_capture_unit`

## Requirements
- R1: After reset, the mode register reads 0x00100120: snoop (bit 20), queue-full interrupt enable (bit 8) and error interrupt enable (bit 5) are set and enable (bit 0) is clear. The status register reads 0, `irq` is 0 and `in_ready` is 1.
- R2: A packet of exactly 16 words that starts while enable is 1 and the slot is empty is stored. From the cycle after its last word, status bit 20 (slot full) and bit 4 (full interrupt flag) are set. Address 16+i then returns word i in the order of arrival.
- R3: A packet that starts while enable is 1 and the slot is full is dropped. It sets status bit 3 (discarded) whatever its length, does not set bit 7, and leaves the stored words unchanged.
- R4: A packet that starts while enable is 1 and the slot is empty, but whose length is not 16 words (for example 1, 5 or 17), sets status bit 7 (transaction error) and does not set bit 20.
- R5: A packet that starts while enable is 0 is consumed with `in_ready` high and changes no status bit.
- R6: Writing 1 to status bit 3 or bit 4 clears that flag, and writing 0 leaves it unchanged. Writing 1 to bit 7 clears it only while mode bit 0 is 0.
- R7: Writing mode bit 1 (clear-queue) releases the slot (bit 20 goes to 0) only if status bit 4 is already 0; otherwise the write has no effect on the slot. Mode bit 1 always reads as 0.
- R8: Status bit 2 (busy) is 1 from the cycle after the first word of a multi-word packet until the cycle after its last word.
- R9: `irq` = (bit 4 AND mode bit 8) OR (bit 7 AND mode bit 5) OR bit 3.
- R10: When an event sets a flag in the same cycle in which software writes 1 to clear that flag, the flag ends up set.
- R11: Only mode bits 0, 5, 8 and 20 are stored. All other mode bits read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Packet word valid |
| in_ready | output | 1 | Word accepted (always 1) |
| in_data | input | 32 | Packet word |
| in_last | input | 1 | Marks the final word of a packet |
| reg_addr | input | 5 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
The collision that matters is a status write-one-to-clear that lands on the same clock edge as the end of a packet that sets the same flag. The bench provokes it twice:
- It holds the clear strobe on the last word of a packet that is dropped into a full slot, and checks that the discarded flag survives.
- It clears the full flag on the last word of a packet that is stored, and checks that the full interrupt flag survives.

In both cases the status register is read in the following cycle, and the flag is expected to be set, because setting takes priority over clearing.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  // mode register bit positions
  localparam int MODE_EN    = 0;
  localparam int MODE_CQ    = 1;
  localparam int MODE_EIE   = 5;
  localparam int MODE_QFIE  = 8;
  localparam int MODE_SNOOP = 20;

  // status register bit positions
  localparam int ST_BUSY = 2;
  localparam int ST_DISC = 3;
  localparam int ST_QFI  = 4;
  localparam int ST_TE   = 7;
  localparam int ST_QF   = 20;

  localparam logic [31:0] MODE_KEEP  = (32'h1 << MODE_EN) | (32'h1 << MODE_EIE) |
                                       (32'h1 << MODE_QFIE) | (32'h1 << MODE_SNOOP);
  localparam logic [31:0] MODE_RESET = (32'h1 << MODE_EIE) | (32'h1 << MODE_QFIE) |
                                       (32'h1 << MODE_SNOOP);

  // sticky flag update: a new event takes priority over a clear request
  function automatic logic flag_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction

  function automatic logic irq_level(logic qfi, logic qfie, logic te, logic eie, logic disc);
    return (qfi & qfie) | (te & eie) | disc;
  endfunction

  function automatic logic [31:0] status_word(logic busy, logic disc, logic qfi,
                                              logic te, logic qf);
    logic [31:0] s;
    s = '0;
    s[ST_BUSY] = busy;
    s[ST_DISC] = disc;
    s[ST_QFI]  = qfi;
    s[ST_TE]   = te;
    s[ST_QF]   = qf;
    return s;
  endfunction

endpackage

// File: rtl/pwr_ingest.sv
module pwr_ingest #(
  parameter int MSG_WORDS = 16,
  parameter int DATA_W    = 32,
  localparam int IDX_W    = $clog2(MSG_WORDS),
  localparam int CNT_W    = $clog2(MSG_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  input  logic              unit_en,
  input  logic              buf_full,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data,
  output logic              evt_commit,
  output logic              evt_drop,
  output logic              evt_lenerr,
  output logic              busy
);

  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(MSG_WORDS);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(MSG_WORDS - 1);

  logic             in_pkt_q;
  logic             cap_q;
  logic             en_q;
  logic [CNT_W-1:0] cnt_q;

  logic             first_beat;
  logic             cap_now;
  logic             en_now;
  logic [CNT_W-1:0] idx;
  logic             end_beat;
  logic             len_ok;

  // capture and enable decisions are frozen at the first word of a packet
  assign first_beat = in_valid && !in_pkt_q;
  assign cap_now    = first_beat ? (unit_en && !buf_full) : cap_q;
  assign en_now     = first_beat ? unit_en : en_q;
  assign idx        = first_beat ? '0 : cnt_q;
  assign end_beat   = in_valid && in_last;
  assign len_ok     = (idx == LAST_IDX);

  assign wr_en      = in_valid && cap_now && (idx < CNT_MAX);
  assign wr_idx     = idx[IDX_W-1:0];
  assign wr_data    = in_data;

  assign evt_commit = end_beat && cap_now && len_ok;
  assign evt_lenerr = end_beat && cap_now && !len_ok;
  assign evt_drop   = end_beat && en_now && !cap_now;
  assign busy       = in_pkt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt_q <= 1'b0;
      cap_q    <= 1'b0;
      en_q     <= 1'b0;
      cnt_q    <= '0;
    end else if (in_valid) begin
      cap_q <= cap_now;
      en_q  <= en_now;
      if (in_last) begin
        in_pkt_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        in_pkt_q <= 1'b1;
        cnt_q    <= (idx == CNT_MAX) ? idx : idx + CNT_W'(1);
      end
    end
  end

  AST_NO_STORE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (first_beat && buf_full) |-> !wr_en); // R3

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_commit, evt_drop, evt_lenerr})); // R4

  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (first_beat && in_last && !unit_en) |-> !(evt_commit || evt_drop || evt_lenerr)); // R5

endmodule

// File: rtl/pwr_msgbuf.sv
module pwr_msgbuf #(
  parameter int MSG_WORDS = 16,
  parameter int DATA_W    = 32,
  localparam int IDX_W    = $clog2(MSG_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] words [MSG_WORDS];

  for (genvar w = 0; w < MSG_WORDS; w++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  word_q <= '0;
      else if (wr_en && wr_idx == IDX_W'(w))       word_q <= wr_data;
    end
    assign words[w] = word_q;
  end

  assign rd_data = words[rd_idx];

  AST_WORD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (words[$past(wr_idx)] == $past(wr_data))); // R2

endmodule

// File: rtl/pwr_regs.sv
module pwr_regs
  import pwr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        sel_mode,
  input  logic        sel_stat,
  input  logic [31:0] reg_wdata,
  input  logic        evt_commit,
  input  logic        evt_drop,
  input  logic        evt_lenerr,
  input  logic        busy,
  output logic [31:0] mode_rd,
  output logic [31:0] stat_rd,
  output logic        unit_en,
  output logic        buf_full,
  output logic        irq
);

  logic [31:0] mode_q;
  logic        qf_q, qfi_q, te_q, disc_q;

  logic wr_mode, wr_stat, cq_go;
  logic clr_disc, clr_qfi, clr_te;

  assign wr_mode  = reg_wr && sel_mode;
  assign wr_stat  = reg_wr && sel_stat;
  assign cq_go    = wr_mode && reg_wdata[MODE_CQ];
  assign clr_disc = wr_stat && reg_wdata[ST_DISC];
  assign clr_qfi  = wr_stat && reg_wdata[ST_QFI];
  assign clr_te   = wr_stat && reg_wdata[ST_TE] && !mode_q[MODE_EN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RESET;
      qf_q   <= 1'b0;
      qfi_q  <= 1'b0;
      te_q   <= 1'b0;
      disc_q <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= reg_wdata & MODE_KEEP;
      qfi_q  <= flag_next(qfi_q,  evt_commit, clr_qfi);
      te_q   <= flag_next(te_q,   evt_lenerr, clr_te);
      disc_q <= flag_next(disc_q, evt_drop,   clr_disc);
      if (evt_commit)          qf_q <= 1'b1;
      else if (cq_go && !qfi_q) qf_q <= 1'b0;
    end
  end

  assign mode_rd  = mode_q;
  assign stat_rd  = status_word(busy, disc_q, qfi_q, te_q, qf_q);
  assign unit_en  = mode_q[MODE_EN];
  assign buf_full = qf_q;
  assign irq      = irq_level(qfi_q, mode_q[MODE_QFIE], te_q, mode_q[MODE_EIE], disc_q);

  AST_COMMIT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_commit |=> (qf_q && qfi_q)); // R2

  AST_DROP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    evt_drop |=> disc_q); // R3

  AST_TE_LOCKED_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[MODE_EN] && te_q) |=> te_q); // R6

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (qf_q && !(reg_wr && sel_mode && reg_wdata[MODE_CQ])) |=> qf_q); // R7

  AST_DISC_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    disc_q |-> irq); // R9

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_commit && wr_stat && reg_wdata[ST_QFI]) |=> qfi_q); // R10

endmodule

// File: rtl/pwr_capture_unit.sv
module pwr_capture_unit #(
  parameter int MSG_WORDS = 16,
  parameter int DATA_W    = 32,
  localparam int IDX_W    = $clog2(MSG_WORDS),
  localparam int ADDR_W   = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] ADDR_MODE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(1);

  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data;
  logic              evt_commit, evt_drop, evt_lenerr, busy;
  logic              unit_en, buf_full;
  logic [31:0]       mode_rd, stat_rd;
  logic [DATA_W-1:0] buf_rd;
  logic              sel_mode, sel_stat, sel_buf;

  assign in_ready = 1'b1;
  assign sel_buf  = reg_addr[ADDR_W-1];
  assign sel_mode = (reg_addr == ADDR_MODE);
  assign sel_stat = (reg_addr == ADDR_STAT);

  pwr_ingest #(.MSG_WORDS(MSG_WORDS), .DATA_W(DATA_W)) u_ingest (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .unit_en(unit_en), .buf_full(buf_full),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .evt_commit(evt_commit), .evt_drop(evt_drop), .evt_lenerr(evt_lenerr),
    .busy(busy)
  );

  pwr_msgbuf #(.MSG_WORDS(MSG_WORDS), .DATA_W(DATA_W)) u_msgbuf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(reg_addr[IDX_W-1:0]), .rd_data(buf_rd)
  );

  pwr_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .sel_mode(sel_mode), .sel_stat(sel_stat), .reg_wdata(reg_wdata),
    .evt_commit(evt_commit), .evt_drop(evt_drop), .evt_lenerr(evt_lenerr), .busy(busy),
    .mode_rd(mode_rd), .stat_rd(stat_rd), .unit_en(unit_en), .buf_full(buf_full),
    .irq(irq)
  );

  always_comb begin
    if (sel_buf)       reg_rdata = 32'(buf_rd);
    else if (sel_mode) reg_rdata = mode_rd;
    else if (sel_stat) reg_rdata = stat_rd;
    else               reg_rdata = '0;
  end

  AST_CQ_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_MODE) |-> !reg_rdata[1]); // R7

endmodule

// File: tb/test_pwr_capture_unit.sv
`timescale 1ns/1ps
module test_pwr_capture_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        in_last = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  pwr_capture_unit i_pwr_capture_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  localparam logic [31:0] M_EN  = 32'h0010_0121;
  localparam logic [31:0] M_DIS = 32'h0010_0120;

  typedef struct packed {
    logic [31:0] mode;
    logic        pre;
    logic [7:0]  len;
    logic [31:0] st;
    logic        irq;
    logic [7:0]  req;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{M_EN,  1'b0, 8'd16, 32'h0010_0010, 1'b1, 8'd2},  // R2 stored
    '{M_EN,  1'b0, 8'd5,  32'h0000_0080, 1'b1, 8'd4},  // R4 short
    '{M_EN,  1'b0, 8'd17, 32'h0000_0080, 1'b1, 8'd4},  // R4 long
    '{M_EN,  1'b1, 8'd16, 32'h0010_0018, 1'b1, 8'd3},  // R3 dropped when full
    '{M_DIS, 1'b0, 8'd16, 32'h0000_0000, 1'b0, 8'd5},  // R5 disabled
    '{M_DIS, 1'b0, 8'd2,  32'h0000_0000, 1'b0, 8'd5},  // R5 disabled short
    '{M_EN,  1'b0, 8'd1,  32'h0000_0080, 1'b1, 8'd4},  // R4 single word
    '{M_EN,  1'b1, 8'd3,  32'h0010_0018, 1'b1, 8'd3}   // R3 bad length while full
  };

  function automatic logic [31:0] pkt_word(logic [7:0] tag, int i);
    return {8'hA5, tag, 8'h00, 8'(i)};
  endfunction

  task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; reg_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic reg_write(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // collide=1 raises a status write on the same cycle as the last word
  task automatic send_pkt(int len, logic [7:0] tag, bit collide, logic [31:0] cw);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = pkt_word(tag, i);
      in_last  = (i == len - 1);
      if (collide && i == len - 1) begin
        reg_addr = 5'd1; reg_wdata = cw; reg_wr = 1'b1;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; reg_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;

    // R1 reset state
    do_reset();
    reg_read(5'd0, v); check("R1", "mode reset", v, 32'h0010_0120);
    reg_read(5'd1, v); check("R1", "status reset", v, 32'h0);
    check("R1", "irq reset", 32'(irq), 32'h0);
    check("R1", "ready", 32'(in_ready), 32'h1);

    // table walk
    for (int r = 0; r < 8; r++) begin
      string rq;
      rq = $sformatf("R%0d", VECS[r].req);
      do_reset();
      reg_write(5'd0, VECS[r].mode);
      if (VECS[r].pre) send_pkt(16, 8'hEE, 1'b0, 32'h0);
      send_pkt(int'(VECS[r].len), 8'(r), 1'b0, 32'h0);
      reg_read(5'd1, v); check(rq, $sformatf("row %0d status", r), v, VECS[r].st);
      check(rq, $sformatf("row %0d irq", r), 32'(irq), 32'(VECS[r].irq));
      if (VECS[r].pre) begin
        reg_read(5'd16, v); check("R3", "kept word0", v, pkt_word(8'hEE, 0));
        reg_read(5'd31, v); check("R3", "kept word15", v, pkt_word(8'hEE, 15));
      end else if (VECS[r].st[20]) begin
        for (int w = 0; w < 16; w++) begin
          reg_read(5'(16 + w), v); check("R2", $sformatf("word %0d", w), v, pkt_word(8'(r), w));
        end
      end
    end

    // R11 mode bit storage, R7 clear-queue reads zero
    do_reset();
    reg_write(5'd0, 32'hFFFF_FFFF);
    reg_read(5'd0, v); check("R11", "mode mask", v, 32'h0010_0121);
    check("R7", "cq reads 0", 32'(v[1]), 32'h0);
    reg_write(5'd0, 32'h0);
    reg_read(5'd0, v); check("R11", "mode zero", v, 32'h0);

    // R7 release order, R6 write-one-to-clear
    do_reset();
    reg_write(5'd0, M_EN);
    send_pkt(16, 8'h11, 1'b0, 32'h0);
    reg_write(5'd0, M_EN | 32'h2);
    reg_read(5'd1, v); check("R7", "cq with flag set ignored", v, 32'h0010_0010);
    reg_write(5'd1, 32'h0);
    reg_read(5'd1, v); check("R6", "write zero keeps flags", v, 32'h0010_0010);
    reg_write(5'd1, 32'h10);
    reg_read(5'd1, v); check("R6", "qfi cleared", v, 32'h0010_0000);
    reg_write(5'd0, M_EN | 32'h2);
    reg_read(5'd1, v); check("R7", "slot released", v, 32'h0);
    send_pkt(16, 8'h22, 1'b0, 32'h0);
    reg_read(5'd1, v); check("R7", "second packet stored", v, 32'h0010_0010);
    reg_read(5'd19, v); check("R2", "second packet word3", v, pkt_word(8'h22, 3));

    // R6 transaction error clear only when disabled
    do_reset();
    reg_write(5'd0, M_EN);
    send_pkt(4, 8'h33, 1'b0, 32'h0);
    reg_read(5'd1, v); check("R4", "te set", v, 32'h80);
    reg_write(5'd1, 32'h80);
    reg_read(5'd1, v); check("R6", "te kept while enabled", v, 32'h80);
    reg_write(5'd0, M_DIS);
    reg_write(5'd1, 32'h80);
    reg_read(5'd1, v); check("R6", "te cleared while disabled", v, 32'h0);

    // R8 busy
    do_reset();
    reg_write(5'd0, M_EN);
    reg_addr = 5'd1;
    @(negedge clk);
    in_valid = 1'b1; in_data = pkt_word(8'h44, 0); in_last = 1'b0;
    @(negedge clk);
    #1; check("R8", "busy mid packet", 32'(reg_rdata[2]), 32'h1);
    for (int i = 1; i < 16; i++) begin
      in_valid = 1'b1; in_data = pkt_word(8'h44, i); in_last = (i == 15);
      @(negedge clk);
      #1;
    end
    in_valid = 1'b0; in_last = 1'b0;
    reg_read(5'd1, v); check("R8", "busy cleared", v, 32'h0010_0010);

    // R9 interrupt composition
    do_reset();
    reg_write(5'd0, 32'h1);
    send_pkt(16, 8'h55, 1'b0, 32'h0);
    check("R9", "qfi masked", 32'(irq), 32'h0);
    reg_write(5'd0, 32'h101);
    check("R9", "qfi unmasked", 32'(irq), 32'h1);
    reg_write(5'd1, 32'h10);
    check("R9", "qfi cleared", 32'(irq), 32'h0);
    send_pkt(16, 8'h56, 1'b0, 32'h0);
    check("R9", "discard unmaskable", 32'(irq), 32'h1);
    reg_write(5'd1, 32'h8);
    check("R9", "discard cleared", 32'(irq), 32'h0);

    // R10 set beats simultaneous clear
    do_reset();
    reg_write(5'd0, M_EN);
    send_pkt(16, 8'h66, 1'b0, 32'h0);
    reg_write(5'd1, 32'h10);
    send_pkt(2, 8'h67, 1'b1, 32'h8);
    reg_read(5'd1, v); check("R10", "discard set wins", v, 32'h0010_0008);
    reg_write(5'd1, 32'h18);
    reg_write(5'd0, M_EN | 32'h2);
    send_pkt(16, 8'h68, 1'b1, 32'h10);
    reg_read(5'd1, v); check("R10", "qfi set wins", v, 32'h0010_0010);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule